// File: doc/BRIEF.md
# Interleaved Conversion Output Selector and Formatter

This block sits at the back end of a time-interleaved converter built from sixteen identical conversion slices. Each slice delivers an 11-bit raw result, and in any clock cycle exactly one slice is in its hand-off cycle; a rotating index names that slice. The block picks that slice's result through a 16:1 selector and splits it into a 10-bit straight-binary code and an overrange flag. It registers both on the rising clock edge and presents them on the output pins together with a one-cycle data-valid strobe.

When the top bit of the raw result is set (any result of 1024 or more), the input has passed positive full scale. The overrange pin then goes high and all ten code bits are forced to one, so a downstream system that ignores the flag still sees a saturated code. The pin drivers are modelled by an output-enable signal: an active-high disable input turns the drive off without touching the registered word or the strobe.

A new word is captured on every edge at which the hand-off index differs from the index of the last captured word. The first edge after reset always captures. If the rotation stalls, the outputs hold.

Top module: `ilv_outmux`

## Requirements
- R1: While reset is high at a rising edge, the code output becomes 0, the overrange output 0 and the valid strobe 0.
- R2: A captured word is taken from the slice whose number equals the index input at the capturing edge (slice k occupies bits 11k+10 down to 11k of the flat result bus) and appears on the outputs right after that edge.
- R3: A raw result below 1024 is output as its low ten bits in straight binary (code bit 0 is the least significant) with overrange 0.
- R4: A raw result of 1024 or more (bit 10 set) gives overrange 1 and code 0x3FF, whatever its low bits hold.
- R5: When the index at an edge equals the index of the last captured word, code and overrange keep their values.
- R6: The valid strobe is 1 in the cycle after an edge that captured a word and 0 after an edge that did not.
- R7: The first rising edge with reset low always captures a word, whatever the index.
- R8: The pin drive enable is the inverse of the disable input, combinationally; the disable input changes neither the code, the overrange bit nor the strobe.
- R9: Results of slices not named by the index have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| slice_res | input | 176 | Sixteen 11-bit slice results, slice 0 in the lowest bits |
| xfer_idx | input | 4 | Number of the slice in its hand-off cycle |
| out_dis | input | 1 | Active-high output drive disable |
| code_out | output | 10 | Registered straight-binary code |
| ovr_out | output | 1 | Registered overrange flag |
| dvalid | output | 1 | One cycle high per newly registered word |
| out_drive | output | 1 | High when the pins are driven, low for high impedance |

## Verification
The assertions take for granted that slice results and the index are stable around the rising edge and that reset is held for at least two edges so that past values are defined. They also assume that a changed index means a new hand-off, so a stall is the only way to repeat a slice. The stimulus changes inputs only at the falling edge. It mostly advances the index as a real rotation would, inserts random stalls and jumps, and toggles the disable input freely, while directed cases place the codes 0, 511, 1023, 1024 and 2047 in the selected slice.

// File: rtl/ilv_outmux_pkg.sv
package ilv_outmux_pkg;

    localparam int NUM_SLICES = 16;
    localparam int RES_W      = 11;
    localparam int CODE_W     = RES_W - 1;
    localparam int IDX_W      = $clog2(NUM_SLICES);

    typedef logic [RES_W-1:0]  res_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  ovr;
        code_t code;
    } word_t;

    // Top bit marks overrange; overrange saturates the code to all ones.
    function automatic word_t fmt_word(res_t r);
        word_t w;
        w.ovr  = r[RES_W-1];
        w.code = r[RES_W-1] ? {CODE_W{1'b1}} : r[CODE_W-1:0];
        return w;
    endfunction

endpackage

// File: rtl/ilv_slice_sel.sv
module ilv_slice_sel
    import ilv_outmux_pkg::*;
#(
    parameter int N_SL = NUM_SLICES,
    localparam int SW  = $clog2(N_SL)
) (
    input  logic [N_SL*RES_W-1:0] res_flat,
    input  logic [SW-1:0]         sel,
    output res_t                  res_sel
);

    res_t res_arr [N_SL];

    for (genvar g = 0; g < N_SL; g++) begin : g_unpack
        assign res_arr[g] = res_flat[g*RES_W +: RES_W];
    end

    assign res_sel = res_arr[sel];

endmodule

// File: rtl/ilv_fmt.sv
module ilv_fmt
    import ilv_outmux_pkg::*;
(
    input  res_t  raw,
    output word_t word
);

    always_comb begin
        word = fmt_word(raw);
    end

endmodule

// File: rtl/ilv_out_reg.sv
module ilv_out_reg
    import ilv_outmux_pkg::*;
#(
    parameter int SW = IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] idx,
    input  word_t         word_d,
    output word_t         word_q,
    output logic          vld_q
);

    logic [SW-1:0] last_idx;
    logic          primed;
    logic          take;

    assign take = !primed || (idx != last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            vld_q    <= 1'b0;
            last_idx <= '0;
            primed   <= 1'b0;
        end else begin
            vld_q <= take;
            if (take) begin
                word_q   <= word_d;
                last_idx <= idx;
                primed   <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ilv_outmux.sv
module ilv_outmux
    import ilv_outmux_pkg::*;
#(
    parameter int N_SL = NUM_SLICES,
    localparam int SW  = $clog2(N_SL)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_SL*RES_W-1:0] slice_res,
    input  logic [SW-1:0]         xfer_idx,
    input  logic                  out_dis,
    output logic [CODE_W-1:0]     code_out,
    output logic                  ovr_out,
    output logic                  dvalid,
    output logic                  out_drive
);

    res_t  sel_raw;
    word_t fmt_w;
    word_t reg_w;

    ilv_slice_sel #(.N_SL(N_SL)) u_sel (
        .res_flat (slice_res),
        .sel      (xfer_idx),
        .res_sel  (sel_raw)
    );

    ilv_fmt u_fmt (
        .raw  (sel_raw),
        .word (fmt_w)
    );

    ilv_out_reg #(.SW(SW)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .idx    (xfer_idx),
        .word_d (fmt_w),
        .word_q (reg_w),
        .vld_q  (dvalid)
    );

    assign code_out  = reg_w.code;
    assign ovr_out   = reg_w.ovr;
    assign out_drive = !out_dis;

endmodule

// File: rtl/ilv_outmux_chk.sv
module ilv_outmux_chk
    import ilv_outmux_pkg::*;
#(
    parameter int N_SL = NUM_SLICES,
    localparam int SW  = $clog2(N_SL)
) (
    input logic                  clk,
    input logic                  rst,
    input logic [N_SL*RES_W-1:0] slice_res,
    input logic [SW-1:0]         xfer_idx,
    input logic [CODE_W-1:0]     code_out,
    input logic                  ovr_out,
    input logic                  dvalid
);

    res_t picked;
    assign picked = slice_res[xfer_idx*RES_W +: RES_W];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (code_out == '0 && !ovr_out && !dvalid)); // R1

    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (rst)
        ovr_out |-> (code_out == {CODE_W{1'b1}})); // R4

    AST_OVR_FROM_SLICE: assert property (@(posedge clk) disable iff (rst)
        (dvalid && !$past(rst)) |-> (ovr_out == $past(picked[RES_W-1]))); // R2

    AST_CODE_FROM_SLICE: assert property (@(posedge clk) disable iff (rst)
        (dvalid && !ovr_out && !$past(rst)) |-> (code_out == $past(picked[CODE_W-1:0]))); // R3

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (!dvalid && !$past(rst)) |-> ($stable(code_out) && $stable(ovr_out))); // R5

    AST_VALID_ON_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (xfer_idx != $past(xfer_idx)) |=> dvalid); // R6

    AST_NO_VALID_ON_STALL: assert property (@(posedge clk) disable iff (rst)
        (xfer_idx == $past(xfer_idx) && !$past(rst)) |=> !dvalid); // R6

    AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |=> dvalid); // R7

endmodule

bind ilv_outmux ilv_outmux_chk #(.N_SL(N_SL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .slice_res (slice_res),
    .xfer_idx  (xfer_idx),
    .code_out  (code_out),
    .ovr_out   (ovr_out),
    .dvalid    (dvalid)
);

// File: tb/ilv_outmux_bench.sv
module ilv_outmux_bench;

    localparam int  CLK_PERIOD = 10;
    localparam int  NS  = 16;
    localparam int  RW  = 11;
    localparam int  CW  = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NS*RW-1:0] slice_res = '0;
    logic [3:0]       xfer_idx = '0;
    logic             out_dis = 1'b0;
    logic [CW-1:0]    code_out;
    logic             ovr_out;
    logic             dvalid;
    logic             out_drive;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [CW-1:0] m_code = '0;
    logic          m_ovr  = 1'b0;
    logic          m_vld  = 1'b0;
    logic [3:0]    m_last = '0;
    logic          m_primed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_outmux u_ilv_outmux (
        .clk       (clk),
        .rst       (rst),
        .slice_res (slice_res),
        .xfer_idx  (xfer_idx),
        .out_dis   (out_dis),
        .code_out  (code_out),
        .ovr_out   (ovr_out),
        .dvalid    (dvalid),
        .out_drive (out_drive)
    );

    function automatic logic [CW-1:0] exp_code(input logic [RW-1:0] r);
        if (r >= 11'd1024) return 10'h3FF;
        return r[CW-1:0];
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_slice(input int k, input logic [RW-1:0] v);
        slice_res[k*RW +: RW] = v;
    endtask

    // Apply inputs (already set at negedge), advance one edge, update model, compare.
    task automatic step(input string req);
        logic [RW-1:0] r;
        logic take;
        r = slice_res[xfer_idx*RW +: RW];
        @(posedge clk);
        if (rst) begin
            m_code = '0; m_ovr = 1'b0; m_vld = 1'b0; m_last = '0; m_primed = 1'b0;
        end else begin
            take = !m_primed || (xfer_idx != m_last);
            m_vld = take;
            if (take) begin
                m_code = exp_code(r); m_ovr = r[RW-1]; m_last = xfer_idx; m_primed = 1'b1;
            end
        end
        @(negedge clk);
        chk({req, " code"},  int'(code_out), int'(m_code));
        chk({req, " ovr"},   int'(ovr_out),  int'(m_ovr));
        chk({req, " valid"}, int'(dvalid),   int'(m_vld));
        chk("R8 drive", int'(out_drive), int'(!out_dis));
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < NS; k++) set_slice(k, 11'($urandom()));
        @(negedge clk);
        step("R1 reset");
        step("R1 reset");
        rst = 1'b0;
        xfer_idx = 4'd0;
        step("R7 first capture");

        // directed codes on the selected slice; others hold a distracting value
        begin
            logic [RW-1:0] dir [5] = '{11'd0, 11'd511, 11'd1023, 11'd1024, 11'd2047};
            for (int i = 0; i < 5; i++) begin
                xfer_idx = xfer_idx + 4'd1;
                for (int k = 0; k < NS; k++) set_slice(k, 11'h555);
                set_slice(int'(xfer_idx), dir[i]);
                step(dir[i] >= 1024 ? "R4 overrange" : "R3 binary");
            end
        end

        // R5/R6 stall holds; R9 other slices changed during stall
        for (int k = 0; k < NS; k++) if (k != int'(xfer_idx)) set_slice(k, 11'($urandom()));
        step("R5 stall hold");

        // R8 disable toggling with stall: word undisturbed
        out_dis = 1'b1;
        step("R8 disable");
        out_dis = 1'b0;
        step("R8 re-enable");

        // R2 selection with jump and disable during capture
        xfer_idx = 4'd9; set_slice(9, 11'd300); out_dis = 1'b1;
        step("R2 select");
        out_dis = 1'b0;

        // R4: overrange with nonzero low bits
        xfer_idx = 4'd10; set_slice(10, 11'h412);
        step("R4 overrange");

        // random rotation with stalls
        for (int n = 0; n < 2000; n++) begin
            for (int k = 0; k < NS; k++) set_slice(k, 11'($urandom()));
            case ($urandom_range(0, 9))
                0:       ;                                   // stall
                1:       xfer_idx = 4'($urandom());          // jump
                default: xfer_idx = xfer_idx + 4'd1;         // rotate
            endcase
            out_dis = ($urandom_range(0, 3) == 0);
            step("R2 R6 random");
        end

        // reset again mid-run
        rst = 1'b1;
        step("R1 reset again");
        rst = 1'b0;
        step("R7 first after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule